// File: doc/BRIEF.md
# Flash Erase Busy and Status Poller

This block keeps the status byte that a host reads again and again while a flash program or erase operation runs. The host tells operations apart by two bits: bit 6 flips on every status read, so a reader that sees two different values in a row knows work is still going on. Bit 7 is inverted when the operation completes. A program is treated as finishing at once. An erase keeps the block busy for a wait measured in clock cycles, and a chip erase waits ten times longer than a sector erase.

A command sequencer drives the block with four inputs: a program event that carries the written data byte, a sector-erase start, a chip-erase start, and a status-read strobe. When an operation completes, the block sends back a one-cycle done pulse. A qualifier sent with the pulse tells the sequencer whether to go back to the bypass command state or to plain read mode. Clearing the memory array and decoding commands are done elsewhere.

The program event is a single-cycle valid with its data and has no back-pressure. Every beat offered is consumed in the cycle it is valid. A beat that arrives while an erase is busy is dropped, so the source never needs to hold data.

Top module: `flash_status_poller`

## Requirements
- R1: In a cycle where `status_rd` is high and no program or erase is accepted, `status_byte` bit 6 is inverted one cycle later. The value shown in the read cycle is the value before the inversion.
- R2: When the block is idle, a program beat makes `status_byte` equal to {~prog_data[7], 7'b1111111} one cycle later. `done` pulses in that same next cycle and `busy` stays low.
- R3: When the block is idle, a sector-erase or chip-erase start makes `status_byte` 8'h00 and `busy` high one cycle later.
- R4: After a sector-erase start, `busy` stays high for exactly SECTOR_WAIT cycles. In the cycle `busy` falls, `done` is high for one cycle and `status_byte` bit 7 has been inverted.
- R5: A chip erase keeps `busy` high for exactly SECTOR_WAIT*CHIP_FACTOR cycles, with CHIP_FACTOR defaulting to 10. A chip start wins over a sector start in the same cycle.
- R6: `done_bypass` goes high together with `done` when `bypass_en` was high in the completing cycle. Otherwise `done_bypass` stays low.
- R7: While `busy` is high, program beats and erase starts are ignored. Bits 6..0 of `status_byte` do not change unless a read toggles bit 6, and the busy window keeps its original length.
- R8: Reset, including a reset in the middle of an erase, clears `status_byte` to 8'h00 and drops `busy` and `done`. No completion follows it.
- R9: When the block is idle, an erase start in the same cycle as a program beat or a read wins: the status becomes 8'h00 and the read does not toggle bit 6.
- R10: A read in the completing cycle inverts bit 6 and bit 7 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_valid | input | 1 | Program beat, single cycle |
| prog_data | input | 8 | Data byte written by the program |
| sector_start | input | 1 | Start of a sector erase |
| chip_start | input | 1 | Start of a chip erase |
| status_rd | input | 1 | Status read strobe |
| bypass_en | input | 1 | Bypass mode is active in the sequencer |
| status_byte | output | 8 | Current status byte |
| busy | output | 1 | Erase wait in progress |
| done | output | 1 | One-cycle completion pulse |
| done_bypass | output | 1 | Completion returns to the bypass command state |

## Verification
The status byte is first driven by a table of reads and programs. The programs use data with bit 7 set and with bit 7 clear, and reads come both after programs and back to back. This separates the bit-6 toggle from the bit-7 complement that a program loads. Sector and chip erases are timed by counting busy cycles, which tells the two wait lengths and their priority apart. Directed cases then cover the following:
- programs and starts arriving during an erase;
- a read that lands exactly on the completing edge, which shows whether both bits invert together;
- completion with and without bypass;
- a reset in the middle of a chip erase.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int STAT_W     = 8;
  localparam int TOGGLE_POS = 6;
  localparam int DONE_POS   = 7;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_PROG   = 2'd1,
    EV_SECTOR = 2'd2,
    EV_CHIP   = 2'd3
  } fsp_event_e;
endpackage

// File: rtl/fsp_event_arb.sv
module fsp_event_arb
  import fsp_pkg::*;
(
  input  logic       busy,
  input  logic       prog_valid,
  input  logic       sector_start,
  input  logic       chip_start,
  output fsp_event_e ev
);
  // Requests are dropped while busy; chip > sector > program when idle.
  always_comb begin
    ev = EV_NONE;
    if (!busy) begin
      if (chip_start)        ev = EV_CHIP;
      else if (sector_start) ev = EV_SECTOR;
      else if (prog_valid)   ev = EV_PROG;
    end
  end
endmodule

// File: rtl/fsp_countdown.sv
module fsp_countdown #(
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN  = 40,
  localparam int CNT_W    = $clog2(LONG_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_short,
  input  logic load_long,
  output logic busy,
  output logic fire
);
  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_LEN);
  localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_LEN);
  localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign fire = busy && (cnt_q == ONE_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (busy) begin
      if (fire) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q - ONE_V;
      end
    end else if (load_long) begin
      busy  <= 1'b1;
      cnt_q <= LONG_V;
    end else if (load_short) begin
      busy  <= 1'b1;
      cnt_q <= SHORT_V;
    end
  end
endmodule

// File: rtl/fsp_status_reg.sv
module fsp_status_reg
  import fsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  fsp_event_e        ev,
  input  logic              prog_msb,
  input  logic              rd,
  input  logic              fire,
  output logic [STAT_W-1:0] status
);
  logic [STAT_W-1:0] flip_mask;
  logic [STAT_W-1:0] held_next;
  logic [STAT_W-1:0] prog_val;

  // One slice per bit: toggle on read at bit 6, invert on completion at bit 7.
  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (b == TOGGLE_POS) begin : g_tog
      assign flip_mask[b] = rd;
    end else if (b == DONE_POS) begin : g_done
      assign flip_mask[b] = fire;
    end else begin : g_keep
      assign flip_mask[b] = 1'b0;
    end
    assign held_next[b] = status[b] ^ flip_mask[b];
    if (b == DONE_POS) begin : g_pmsb
      assign prog_val[b] = ~prog_msb;
    end else begin : g_pone
      assign prog_val[b] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
    end else begin
      unique case (ev)
        EV_PROG:           status <= prog_val;
        EV_SECTOR, EV_CHIP: status <= '0;
        default:           status <= held_next;
      endcase
    end
  end
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
  import fsp_pkg::*;
#(
  parameter int SECTOR_WAIT = 1000,
  parameter int CHIP_FACTOR = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_valid,
  input  logic [STAT_W-1:0] prog_data,
  input  logic              sector_start,
  input  logic              chip_start,
  input  logic              status_rd,
  input  logic              bypass_en,
  output logic [STAT_W-1:0] status_byte,
  output logic              busy,
  output logic              done,
  output logic              done_bypass
);
  localparam int CHIP_WAIT = SECTOR_WAIT * CHIP_FACTOR;

  fsp_event_e ev;
  logic       fire;
  logic       finish;

  fsp_event_arb u_arb (
    .busy        (busy),
    .prog_valid  (prog_valid),
    .sector_start(sector_start),
    .chip_start  (chip_start),
    .ev          (ev)
  );

  fsp_countdown #(
    .SHORT_LEN(SECTOR_WAIT),
    .LONG_LEN (CHIP_WAIT)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_short(ev == EV_SECTOR),
    .load_long (ev == EV_CHIP),
    .busy      (busy),
    .fire      (fire)
  );

  fsp_status_reg u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev),
    .prog_msb(prog_data[DONE_POS]),
    .rd      (status_rd),
    .fire    (fire),
    .status  (status_byte)
  );

  assign finish = fire || (ev == EV_PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      done_bypass <= 1'b0;
    end else begin
      done        <= finish;
      done_bypass <= finish && bypass_en;
    end
  end
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
  parameter int SECTOR_WAIT = 1000,
  parameter int CHIP_FACTOR = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_valid,
  input logic [7:0] prog_data,
  input logic       sector_start,
  input logic       chip_start,
  input logic       status_rd,
  input logic [7:0] status_byte,
  input logic       busy,
  input logic       done,
  input logic       done_bypass
);
  logic [31:0] run_cnt;
  logic [31:0] exp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      exp_len <= '0;
    end else if (!busy && (chip_start || sector_start)) begin
      run_cnt <= '0;
      exp_len <= chip_start ? 32'(SECTOR_WAIT * CHIP_FACTOR) : 32'(SECTOR_WAIT);
    end else if (busy) begin
      run_cnt <= run_cnt + 32'd1;
    end
  end

  AST_RD_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && (busy || (!prog_valid && !sector_start && !chip_start)))
      |=> (status_byte[6] != $past(status_byte[6]))); // R1

  AST_PROG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && prog_valid && !sector_start && !chip_start)
      |=> (status_byte == {~$past(prog_data[7]), 7'h7F}) && done && !busy); // R2

  AST_ERASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (sector_start || chip_start))
      |=> (status_byte == 8'h00) && busy); // R3

  AST_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R4

  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == exp_len)); // R5

  AST_BYP_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    done_bypass |-> done); // R6

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !status_rd) |=> (status_byte[6:0] == $past(status_byte[6:0]))); // R7
endmodule

bind flash_status_poller fsp_checker #(
  .SECTOR_WAIT(SECTOR_WAIT),
  .CHIP_FACTOR(CHIP_FACTOR)
) u_fsp_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prog_valid  (prog_valid),
  .prog_data   (prog_data),
  .sector_start(sector_start),
  .chip_start  (chip_start),
  .status_rd   (status_rd),
  .status_byte (status_byte),
  .busy        (busy),
  .done        (done),
  .done_bypass (done_bypass)
);

// File: tb/test_flash_status_poller.sv
`timescale 1ns/1ps
module test_flash_status_poller;
  localparam int SW = 4;
  localparam int CF = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_valid = 1'b0;
  logic [7:0] prog_data = 8'h00;
  logic       sector_start = 1'b0;
  logic       chip_start = 1'b0;
  logic       status_rd = 1'b0;
  logic       bypass_en = 1'b0;
  logic [7:0] status_byte;
  logic       busy;
  logic       done;
  logic       done_bypass;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_status_poller #(.SECTOR_WAIT(SW), .CHIP_FACTOR(CF)) i_flash_status_poller (
    .clk(clk), .rst_n(rst_n), .prog_valid(prog_valid), .prog_data(prog_data),
    .sector_start(sector_start), .chip_start(chip_start), .status_rd(status_rd),
    .bypass_en(bypass_en), .status_byte(status_byte), .busy(busy), .done(done),
    .done_bypass(done_bypass)
  );

  // {op[2:0], data[7:0], byp, exp_status[7:0], exp_done, exp_dbyp}; op 0 idle, 1 read, 2 program
  localparam logic [21:0] VEC [11] = '{
    {3'd1, 8'h00, 1'b0, 8'h40, 1'b0, 1'b0},
    {3'd1, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
    {3'd2, 8'h80, 1'b0, 8'h7F, 1'b1, 1'b0},
    {3'd1, 8'h00, 1'b0, 8'h3F, 1'b0, 1'b0},
    {3'd2, 8'h00, 1'b0, 8'hFF, 1'b1, 1'b0},
    {3'd1, 8'h00, 1'b0, 8'hBF, 1'b0, 1'b0},
    {3'd1, 8'h00, 1'b0, 8'hFF, 1'b0, 1'b0},
    {3'd2, 8'h5A, 1'b0, 8'hFF, 1'b1, 1'b0},
    {3'd2, 8'hC3, 1'b1, 8'h7F, 1'b1, 1'b1},
    {3'd1, 8'h00, 1'b1, 8'h3F, 1'b0, 1'b0},
    {3'd0, 8'h00, 1'b0, 8'h3F, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    prog_valid = 1'b0; sector_start = 1'b0; chip_start = 1'b0; status_rd = 1'b0;
  endtask

  // Called at a negedge with inputs already driven for one cycle.
  task automatic tick();
    @(negedge clk);
    clear_in();
  endtask

  // Counts busy cycles after a start that is driven by the caller for one cycle.
  task automatic time_erase(output int len);
    tick();
    len = 0;
    while (busy && len < 1000) begin
      len++;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    chk("R8 reset status", {24'd0, status_byte}, 32'h00);
    chk("R8 reset busy", {31'd0, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 after release done", {31'd0, done}, 0);

    // Table walk: reads (R1), programs (R2), bypass qualifier (R6)
    foreach (VEC[i]) begin
      logic [21:0] v;
      v = VEC[i];
      bypass_en  = v[10];
      status_rd  = (v[21:19] == 3'd1);
      prog_valid = (v[21:19] == 3'd2);
      prog_data  = v[18:11];
      tick();
      chk($sformatf("R1/R2 vec%0d status", i), {24'd0, status_byte}, {24'd0, v[9:2]});
      chk($sformatf("R2 vec%0d done", i), {31'd0, done}, {31'd0, v[1]});
      chk($sformatf("R6 vec%0d done_bypass", i), {31'd0, done_bypass}, {31'd0, v[0]});
      chk($sformatf("R2 vec%0d busy", i), {31'd0, busy}, 0);
    end
    bypass_en = 1'b0;

    // Sector erase: clear and busy (R3), length and completion (R4)
    sector_start = 1'b1;
    tick();
    chk("R3 erase clears status", {24'd0, status_byte}, 32'h00);
    chk("R3 erase sets busy", {31'd0, busy}, 1);
    len = 1;
    while (busy && len < 1000) begin @(negedge clk); if (busy) len++; end
    chk("R4 sector busy length", len, SW);
    chk("R4 done at fall", {31'd0, done}, 1);
    chk("R4 bit7 inverted", {24'd0, status_byte}, 32'h80);
    chk("R6 no bypass on done", {31'd0, done_bypass}, 0);
    @(negedge clk);
    chk("R4 done one cycle", {31'd0, done}, 0);

    // Chip erase wins over sector in same cycle (R5)
    chip_start = 1'b1; sector_start = 1'b1;
    time_erase(len);
    chk("R5 chip busy length", len, SW * CF);
    chk("R5 chip done", {31'd0, done}, 1);

    // Ignored requests during busy (R7), bypass on completion (R6)
    bypass_en = 1'b1;
    sector_start = 1'b1;
    tick();
    prog_valid = 1'b1; prog_data = 8'h00; chip_start = 1'b1;
    tick();
    chk("R7 status untouched while busy", {24'd0, status_byte}, 32'h00);
    len = 2;
    while (busy && len < 1000) begin @(negedge clk); if (busy) len++; end
    chk("R7 window length kept", len, SW);
    chk("R6 done_bypass with bypass", {31'd0, done_bypass}, 1);
    bypass_en = 1'b0;
    @(negedge clk);

    // Read on the completing edge (R10): status 0x80 start is cleared by erase first
    sector_start = 1'b1;
    tick();
    repeat (SW - 1) @(negedge clk);
    status_rd = 1'b1;
    tick();
    chk("R10 read at completion", {24'd0, status_byte}, 32'hC0);
    chk("R10 done", {31'd0, done}, 1);

    // Erase beats program and read in same cycle (R9)
    sector_start = 1'b1; prog_valid = 1'b1; prog_data = 8'h00; status_rd = 1'b1;
    tick();
    chk("R9 erase wins status", {24'd0, status_byte}, 32'h00);
    chk("R9 erase wins busy", {31'd0, busy}, 1);
    chk("R9 no program done", {31'd0, done}, 0);
    repeat (SW + 2) @(negedge clk);

    // Reset in the middle of a chip erase (R8)
    chip_start = 1'b1;
    tick();
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 mid-erase status", {24'd0, status_byte}, 32'h00);
    chk("R8 mid-erase busy", {31'd0, busy}, 0);
    rst_n = 1'b1;
    len = 0;
    repeat (SW * CF + 5) begin
      @(negedge clk);
      if (done || busy) len++;
    end
    chk("R8 no completion after reset", len, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule